// File: doc/BRIEF.md
# Command-Strobed I2C Bus Master

This block is a byte-level I2C bus master that a host steers one bus event at a time. The host pulses one of four command strobes: begin a transfer, end a transfer, send a byte, or receive a byte. The engine then carries out that single event on SCL and on an open-drain SDA and raises one shared completion flag when the event is over. A START that is issued while the engine already owns the bus becomes a repeated START, so transfers can be chained without letting go of the bus. The first byte after any START is the 7-bit slave address followed by the direction bit: 0 means a write to the slave and 1 means a read from it. This framing is the host's job, and the engine sends that byte like any other.

Every SCL phase (low or high) lasts one reload period of a programmable rate counter. At 100 MHz a reload of 499, 124 or 49 gives 100 kHz, 400 kHz or 1 MHz. On a write the engine sends eight bits MSB first, releases SDA for the ninth clock and stores the slave's acknowledge. On a read it samples eight bits at the middle of each SCL high phase and then drives the acknowledge value that came with the command. The host clears the completion flag and the collision flag with a single clear strobe.

The controller is one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_HELD`: the bus is owned and SCL is held low.
- `ST_RS_REL`: SDA is released while SCL is low, before a repeated START.
- `ST_STA_SETUP`: SCL and SDA are both high for the setup time.
- `ST_STA_HOLD`: SDA is low while SCL is high.
- `ST_BIT_LO`: the low phase of a data bit.
- `ST_BIT_HI`: the high phase of a data bit.
- `ST_STO_LO`: SDA is pulled low while SCL is low.
- `ST_STO_HI`: SCL is high while SDA is still low.
- `ST_STO_REL`: SDA has risen and the bus is free for one phase.

Each state moves on at the end of its phase (the rate tick), except the two waiting states, which move on when a command is accepted.
- From `ST_IDLE`, a start command leads to `ST_STA_SETUP`.
- From `ST_HELD`:
  - a start command leads to `ST_RS_REL`;
  - a stop command leads to `ST_STO_LO`;
  - a write or read command leads to `ST_BIT_LO`.
- The phase sequences are:
  - `ST_RS_REL` → `ST_STA_SETUP` → `ST_STA_HOLD` → `ST_HELD`;
  - `ST_BIT_LO` → `ST_BIT_HI`, which returns to `ST_BIT_LO` until the ninth bit and then goes to `ST_HELD`;
  - `ST_STO_LO` → `ST_STO_HI` → `ST_STO_REL` → `ST_IDLE`.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, SCL is high, SDA is released (`sda_oe`=0), and `done_flag`, `wcol`, `busy`, `start_en` and `stop_en` are all 0.
- R2: A START on a free bus holds SDA released with SCL high for one phase, then pulls SDA low with SCL high for one phase, then drives SCL low. Completion comes 2 phases after acceptance, and the bus stays owned.
- R3: A START while the bus is owned is a repeated START. SDA is released during SCL low, SCL rises, and SDA then falls while SCL is high. No STOP appears on the bus, and completion comes 3 phases after acceptance.
- R4: A write sends `wr_data` MSB first over 8 clocks and releases SDA on the 9th clock. SDA changes only while SCL is low, and `ack_rx` takes the SDA level sampled on the 9th clock (0 = ACK, 1 = NACK).
- R5: A read samples SDA at the middle of each SCL high phase, MSB first, into `rd_data`. On the 9th clock it drives `rd_ack_val`, where 0 pulls SDA low (ACK) and 1 releases it.
- R6: `done_flag` is set when SCL falls at the end of the ninth high phase, 18 phases after a byte command is accepted. It is also set when a START or STOP completes, and it stays set until `flag_clr`.
- R7: A STOP pulls SDA low during SCL low, raises SCL, then releases SDA while SCL is high. It completes 3 phases after acceptance, leaving SCL high, SDA released and `busy` 0.
- R8: Each SCL phase lasts max(`div_reload`, 2) + 1 clock cycles.
- R9: `start_en` and `stop_en` read 1 while their condition is being produced and clear themselves when it completes.
- R10: Any command strobe during a busy event is ignored and sets `wcol`. The byte in flight is unaffected.
- R11: A write, read or stop strobe while the bus is free is ignored and sets `wcol`, and no SCL pulse is produced. A START while the bus is owned is not a collision.
- R12: `flag_clr` clears both `done_flag` and `wcol`. If a completion or a collision falls in the same cycle as the clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_reload | input | DIV_W | Phase reload value (phase = max(value, 2) + 1 cycles) |
| cmd_start | input | 1 | Strobe: START, or repeated START when the bus is owned |
| cmd_stop | input | 1 | Strobe: STOP |
| cmd_write | input | 1 | Strobe: send `wr_data` |
| cmd_read | input | 1 | Strobe: receive a byte, then drive `rd_ack_val` |
| wr_data | input | 8 | Byte to send |
| rd_ack_val | input | 1 | Acknowledge to drive after a read (0 = ACK) |
| flag_clr | input | 1 | Clears `done_flag` and `wcol` |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL level (1 = high) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | 8 | Last received byte |
| ack_rx | output | 1 | Acknowledge sampled after a write (1 = NACK) |
| done_flag | output | 1 | Sticky completion flag |
| busy | output | 1 | An event is in progress |
| start_en | output | 1 | START in progress, self-clearing |
| stop_en | output | 1 | STOP in progress, self-clearing |
| wcol | output | 1 | Sticky command-collision flag |

## Verification
The hardest situation to reach is a completion or collision landing in exactly the same cycle as a `flag_clr` pulse. That race decides whether the flag survives. The bench computes the completion cycle from the phase length and places the clear strobe on that edge. A second hard case is a strobe arriving in the middle of a byte. The bench uses a behavioural slave and a bus monitor to fire such a strobe mid-frame and then confirms that the byte already in flight reaches the monitor unchanged. Phase lengths are measured from the monitor for three reload settings, including one below the clamp.

// File: rtl/i2c_cmd_pkg.sv
`timescale 1ns/1ps
package i2c_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_START,
        CMD_STOP,
        CMD_WRITE,
        CMD_READ
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HELD,
        ST_RS_REL,
        ST_STA_SETUP,
        ST_STA_HOLD,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STO_LO,
        ST_STO_HI,
        ST_STO_REL
    } state_e;

endpackage

// File: rtl/i2c_rate_gen.sv
`timescale 1ns/1ps
// Phase timer: tick marks the last cycle of a phase, mid its centre.
module i2c_rate_gen #(
    parameter int DIV_W      = 8,
    parameter int MIN_RELOAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick,
    output logic             mid
);
    localparam logic [DIV_W-1:0] MIN_R = DIV_W'(MIN_RELOAD);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] cnt;

    assign eff  = (reload < MIN_R) ? MIN_R : reload;
    assign tick = run && (cnt == eff);
    assign mid  = run && (cnt == (eff >> 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: a phase never runs past the clamped reload value
    assert_phase_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= eff));

endmodule

// File: rtl/i2c_cmd_gate.sv
`timescale 1ns/1ps
// Decides which strobe is taken and which ones collide.
module i2c_cmd_gate
    import i2c_cmd_pkg::*;
(
    input  logic engine_busy,
    input  logic bus_owned,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic cmd_write,
    input  logic cmd_read,
    output cmd_e accepted,
    output logic collide
);
    logic any_cmd;
    assign any_cmd = cmd_start | cmd_stop | cmd_write | cmd_read;

    always_comb begin
        accepted = CMD_NONE;
        collide  = 1'b0;
        if (engine_busy) begin
            collide = any_cmd;
        end else if (!bus_owned) begin
            if (cmd_start) begin
                accepted = CMD_START;
            end else begin
                collide = any_cmd;
            end
        end else if (cmd_start) begin
            accepted = CMD_START;
        end else if (cmd_stop) begin
            accepted = CMD_STOP;
        end else if (cmd_write) begin
            accepted = CMD_WRITE;
        end else if (cmd_read) begin
            accepted = CMD_READ;
        end
    end
endmodule

// File: rtl/i2c_bit_shifter.sv
`timescale 1ns/1ps
// Nine-bit transmit and receive shift paths with bit position.
module i2c_bit_shifter #(
    parameter int FRAME = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FRAME-1:0] load_bits,
    input  logic             advance,
    input  logic             sample,
    input  logic             sda_in,
    output logic             tx_bit,
    output logic [FRAME-1:0] rx_bits,
    output logic             last_bit
);
    localparam int IDX_W = $clog2(FRAME) + 1;

    logic [FRAME-1:0] tx_sr;
    logic [IDX_W-1:0] idx;

    assign tx_bit   = tx_sr[FRAME-1];
    assign last_bit = (idx == IDX_W'(FRAME - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '1;
            rx_bits <= '0;
            idx     <= '0;
        end else if (load) begin
            tx_sr   <= load_bits;
            rx_bits <= '0;
            idx     <= '0;
        end else begin
            if (sample) begin
                rx_bits <= {rx_bits[FRAME-2:0], sda_in};
            end
            if (advance) begin
                tx_sr <= {tx_sr[FRAME-2:0], 1'b1};
                idx   <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_reload,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ack_val,
    input  logic              flag_clr,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_rx,
    output logic              done_flag,
    output logic              busy,
    output logic              start_en,
    output logic              stop_en,
    output logic              wcol
);
    localparam int FRAME = DATA_W + 1;

    state_e            state, nstate;
    cmd_e              acc;
    logic              collide;
    logic              tick, mid;
    logic              tx_bit, last_bit;
    logic [FRAME-1:0]  rx_bits;
    logic [FRAME-1:0]  load_bits;
    logic              is_read;
    logic              finish;
    logic              bus_owned;

    assign busy      = (state != ST_IDLE) && (state != ST_HELD);
    assign bus_owned = (state == ST_HELD);

    i2c_cmd_gate u_gate (
        .engine_busy (busy),
        .bus_owned   (bus_owned),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .cmd_write   (cmd_write),
        .cmd_read    (cmd_read),
        .accepted    (acc),
        .collide     (collide)
    );

    i2c_rate_gen #(.DIV_W(DIV_W), .MIN_RELOAD(2)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .reload (div_reload),
        .tick   (tick),
        .mid    (mid)
    );

    // write: data then released ack slot; read: released data then own ack
    assign load_bits = (acc == CMD_WRITE) ? {wr_data, 1'b1}
                                          : {{DATA_W{1'b1}}, rd_ack_val};

    i2c_bit_shifter #(.FRAME(FRAME)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((acc == CMD_WRITE) || (acc == CMD_READ)),
        .load_bits (load_bits),
        .advance   ((state == ST_BIT_HI) && tick),
        .sample    ((state == ST_BIT_HI) && mid),
        .sda_in    (sda_i),
        .tx_bit    (tx_bit),
        .rx_bits   (rx_bits),
        .last_bit  (last_bit)
    );

    assign finish = tick && ((state == ST_STA_HOLD) || (state == ST_STO_REL) ||
                             ((state == ST_BIT_HI) && last_bit));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:      if (acc == CMD_START) nstate = ST_STA_SETUP;
            ST_HELD: begin
                unique case (acc)
                    CMD_START:           nstate = ST_RS_REL;
                    CMD_STOP:            nstate = ST_STO_LO;
                    CMD_WRITE, CMD_READ: nstate = ST_BIT_LO;
                    default:             nstate = ST_HELD;
                endcase
            end
            ST_RS_REL:    if (tick) nstate = ST_STA_SETUP;
            ST_STA_SETUP: if (tick) nstate = ST_STA_HOLD;
            ST_STA_HOLD:  if (tick) nstate = ST_HELD;
            ST_BIT_LO:    if (tick) nstate = ST_BIT_HI;
            ST_BIT_HI:    if (tick) nstate = last_bit ? ST_HELD : ST_BIT_LO;
            ST_STO_LO:    if (tick) nstate = ST_STO_HI;
            ST_STO_HI:    if (tick) nstate = ST_STO_REL;
            ST_STO_REL:   if (tick) nstate = ST_IDLE;
            default:      nstate = ST_IDLE;
        endcase
    end

    // registered outputs and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_o     <= 1'b1;
            sda_oe    <= 1'b0;
            rd_data   <= '0;
            ack_rx    <= 1'b0;
            done_flag <= 1'b0;
            wcol      <= 1'b0;
            start_en  <= 1'b0;
            stop_en   <= 1'b0;
            is_read   <= 1'b0;
        end else begin
            if (finish) begin
                done_flag <= 1'b1;
            end else if (flag_clr) begin
                done_flag <= 1'b0;
            end

            if (collide) begin
                wcol <= 1'b1;
            end else if (flag_clr) begin
                wcol <= 1'b0;
            end

            if (acc == CMD_START) start_en <= 1'b1;
            if (acc == CMD_STOP)  stop_en  <= 1'b1;
            if (finish) begin
                start_en <= 1'b0;
                stop_en  <= 1'b0;
            end

            if (acc == CMD_WRITE) is_read <= 1'b0;
            if (acc == CMD_READ)  is_read <= 1'b1;

            unique case (state)
                ST_IDLE, ST_HELD: begin
                end
                ST_RS_REL: begin
                    if (mid)  sda_oe <= 1'b0;
                    if (tick) scl_o  <= 1'b1;
                end
                ST_STA_SETUP: begin
                    if (tick) sda_oe <= 1'b1;
                end
                ST_STA_HOLD: begin
                    if (tick) scl_o <= 1'b0;
                end
                ST_BIT_LO: begin
                    if (mid)  sda_oe <= ~tx_bit;
                    if (tick) scl_o  <= 1'b1;
                end
                ST_BIT_HI: begin
                    if (tick) begin
                        scl_o <= 1'b0;
                        if (last_bit) begin
                            if (is_read) begin
                                rd_data <= rx_bits[FRAME-1:1];
                            end else begin
                                ack_rx <= rx_bits[0];
                            end
                        end
                    end
                end
                ST_STO_LO: begin
                    if (mid)  sda_oe <= 1'b1;
                    if (tick) scl_o  <= 1'b1;
                end
                ST_STO_HI: begin
                    if (tick) sda_oe <= 1'b0;
                end
                ST_STO_REL: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R1: a free bus is released on both wires
    assert_free_bus_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (scl_o && !sda_oe));

    // R4: SDA moves with SCL high only as a START or STOP edge
    assert_sda_quiet_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && state != ST_STA_HOLD && state != ST_STO_REL)
            |-> $stable(sda_oe));

    // R6: the ninth falling SCL of a byte raises the completion flag
    assert_byte_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && tick && last_bit) |=> done_flag);

    // R6: the completion flag is sticky until cleared
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

    // R8: SCL only toggles on a phase boundary
    assert_scl_edge_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |-> $past(tick));

    // R9: condition enables are clear whenever the engine waits
    assert_enables_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_HELD) |-> (!start_en && !stop_en));

    // R10: a strobe during a busy event is flagged
    assert_busy_collides_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_start || cmd_stop || cmd_write || cmd_read)) |=> wcol);

    // R11: byte or stop strobe on a free bus is flagged and starts nothing
    assert_free_bus_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cmd_start && (cmd_stop || cmd_write || cmd_read))
            |=> (wcol && state == ST_IDLE));

endmodule

// File: tb/i2c_cmd_master_test.sv
`timescale 1ns/1ps
module i2c_cmd_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_reload = 8'd4;
    logic       cmd_start = 1'b0, cmd_stop = 1'b0, cmd_write = 1'b0, cmd_read = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_ack_val = 1'b0;
    logic       flag_clr = 1'b0;
    logic       sda_i;
    logic       scl_o, sda_oe, ack_rx, done_flag, busy, start_en, stop_en, wcol;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    i2c_cmd_master uut (
        .clk(clk), .rst_n(rst_n), .div_reload(div_reload),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write), .cmd_read(cmd_read),
        .wr_data(wr_data), .rd_ack_val(rd_ack_val), .flag_clr(flag_clr), .sda_i(sda_i),
        .scl_o(scl_o), .sda_oe(sda_oe), .rd_data(rd_data), .ack_rx(ack_rx),
        .done_flag(done_flag), .busy(busy), .start_en(start_en), .stop_en(stop_en), .wcol(wcol)
    );

    // behavioural slave
    logic       slv_en = 1'b0, slv_mode = 1'b0, slv_ack = 1'b0;
    logic [7:0] slv_tx = 8'h00;
    int         slv_base = 0;
    int         n_falls = 0, n_rises = 0, n_start = 0, n_stop = 0;
    int         hi_run = 0, last_hi = 0;
    logic       slv_pull;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic [8:0] mon_shift = '0;

    always_comb begin
        int b;
        b = n_falls - slv_base;
        slv_pull = 1'b0;
        if (slv_en) begin
            if (slv_mode) begin
                if (b >= 0 && b < 8) slv_pull = !slv_tx[7 - b];
            end else begin
                slv_pull = (b == 8) && slv_ack;
            end
        end
    end

    assign sda_i = ~sda_oe & ~slv_pull;

    // bus monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_o && prev_scl && sda_i != prev_sda) begin
                if (!sda_i) n_start++; else n_stop++;
            end
            if (scl_o && !prev_scl) begin
                mon_shift <= {mon_shift[7:0], sda_i};
                n_rises++;
            end
            if (!scl_o && prev_scl) n_falls++;
            if (scl_o) hi_run++;
            else if (prev_scl) begin last_hi = hi_run; hi_run = 0; end
            else hi_run = 0;
        end
        prev_scl <= scl_o;
        prev_sda <= sda_i;
    end

    int n_cmp = 0, n_bad = 0;
    int plen = 5;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // kind: 0 start, 1 stop, 2 write, 3 read
    task automatic run_cmd(input int kind, input logic [7:0] d, input logic a,
                           output int lat, output logic en_s, output logic en_p);
        @(negedge clk);
        slv_base   = n_falls;
        slv_en     = (kind >= 2);
        wr_data    = d;
        rd_ack_val = a;
        cmd_start  = (kind == 0);
        cmd_stop   = (kind == 1);
        cmd_write  = (kind == 2);
        cmd_read   = (kind == 3);
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_write = 1'b0; cmd_read = 1'b0;
        en_s = start_en;
        en_p = stop_en;
        lat = 0;
        while (!done_flag && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // [9] read, [8:1] byte, [0] write: slave acks / read: master ack value
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 8'hA6, 1'b1},
        {1'b0, 8'h3C, 1'b0},
        {1'b1, 8'h5A, 1'b0},
        {1'b1, 8'hC3, 1'b1},
        {1'b0, 8'hFF, 1'b1},
        {1'b1, 8'h00, 1'b0}
    };

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int   lat;
        logic es, ep;
        int   s0, p0, r0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 scl", scl_o, 1);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 done", done_flag, 0);
        check("R1 wcol", wcol, 0);
        check("R1 busy", busy, 0);
        check("R1 enables", {start_en, stop_en}, 0);

        // START on free bus
        s0 = n_start;
        run_cmd(0, 8'h00, 1'b0, lat, es, ep);
        check("R2 start latency", lat, 2 * plen);
        check("R2 start seen", n_start - s0, 1);
        check("R2 scl low after", scl_o, 0);
        check("R9 start_en while busy", es, 1);
        check("R9 start_en cleared", start_en, 0);
        pulse_clr();
        check("R12 done cleared", done_flag, 0);

        // vector table of bytes
        foreach (VEC[i]) begin
            s0 = n_start; p0 = n_stop;
            slv_mode = VEC[i][9];
            slv_ack  = VEC[i][0];
            slv_tx   = VEC[i][8:1];
            run_cmd(VEC[i][9] ? 3 : 2, VEC[i][8:1], VEC[i][0], lat, es, ep);
            check("R6 byte latency", lat, 18 * plen);
            check("R4 no start/stop inside byte", (n_start - s0) + (n_stop - p0), 0);
            if (VEC[i][9]) begin
                check("R5 read data", rd_data, VEC[i][8:1]);
                check("R5 ninth bit driven", mon_shift[0], VEC[i][0]);
            end else begin
                check("R4 bits on bus", mon_shift[8:1], VEC[i][8:1]);
                check("R4 ack status", ack_rx, !VEC[i][0]);
            end
            check("R8 high phase", last_hi, plen);
            repeat (3) @(negedge clk);
            check("R6 flag sticky", done_flag, 1);
            pulse_clr();
        end

        // repeated START
        s0 = n_start; p0 = n_stop;
        run_cmd(0, 8'h00, 1'b0, lat, es, ep);
        check("R3 rstart latency", lat, 3 * plen);
        check("R3 start seen", n_start - s0, 1);
        check("R3 no stop", n_stop - p0, 0);
        check("R11 rstart not a collision", wcol, 0);
        pulse_clr();

        // collision mid-byte
        slv_mode = 1'b0; slv_ack = 1'b1;
        @(negedge clk);
        slv_base = n_falls; slv_en = 1'b1; wr_data = 8'h96; cmd_write = 1'b1;
        @(negedge clk); cmd_write = 1'b0;
        repeat (20) @(negedge clk);
        wr_data = 8'h11; cmd_write = 1'b1;
        @(negedge clk); cmd_write = 1'b0;
        check("R10 wcol set", wcol, 1);
        lat = 0;
        while (!done_flag && lat < 5000) begin @(negedge clk); lat++; end
        check("R10 byte unaffected", mon_shift[8:1], 8'h96);
        check("R10 still owned", busy, 0);
        pulse_clr();
        check("R12 wcol cleared", wcol, 0);
        check("R12 done cleared 2", done_flag, 0);

        // STOP
        p0 = n_stop;
        run_cmd(1, 8'h00, 1'b0, lat, es, ep);
        check("R7 stop latency", lat, 3 * plen);
        check("R7 stop seen", n_stop - p0, 1);
        check("R7 scl high", scl_o, 1);
        check("R7 sda released", sda_oe, 0);
        check("R9 stop_en while busy", ep, 1);
        check("R9 stop_en cleared", stop_en, 0);
        pulse_clr();

        // write on free bus
        r0 = n_rises; s0 = n_start;
        @(negedge clk); wr_data = 8'h00; cmd_write = 1'b1;
        @(negedge clk); cmd_write = 1'b0;
        check("R11 wcol on free bus", wcol, 1);
        repeat (12) @(negedge clk);
        check("R11 no clocks", n_rises - r0, 0);
        check("R11 no start", n_start - s0, 0);
        check("R11 still idle", busy, 0);
        pulse_clr();

        // completion and clear in the same cycle
        @(negedge clk); cmd_start = 1'b1; slv_en = 1'b0;
        @(negedge clk); cmd_start = 1'b0;
        repeat (2 * plen - 1) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R12 set wins over clear", done_flag, 1);
        pulse_clr();

        // slower rate
        div_reload = 8'd9; plen = 10;
        slv_mode = 1'b0; slv_ack = 1'b1; slv_tx = 8'h00;
        run_cmd(2, 8'h4D, 1'b0, lat, es, ep);
        check("R8 byte latency slow", lat, 18 * plen);
        check("R8 high phase slow", last_hi, plen);
        check("R4 bits slow", mon_shift[8:1], 8'h4D);
        pulse_clr();

        // clamped rate
        div_reload = 8'd0; plen = 3;
        slv_mode = 1'b1; slv_tx = 8'hB2;
        run_cmd(3, 8'h00, 1'b1, lat, es, ep);
        check("R8 byte latency clamped", lat, 18 * plen);
        check("R8 high phase clamped", last_hi, plen);
        check("R5 read clamped", rd_data, 8'hB2);
        pulse_clr();
        run_cmd(1, 8'h00, 1'b0, lat, es, ep);
        check("R7 stop latency clamped", lat, 3 * plen);
        check("R7 busy low", busy, 0);

        summary();
        $finish;
    end

endmodule